// File: doc/BRIEF.md
# Three-Compare PWM Output Generator

This block produces two pulse-width-modulated outputs from a single down-counting reload timer. A count-source strobe, a single-cycle enable, paces the timer. A reload value `n` sets the period to `n+1` strobes. The first output is high from the start of each period until the count falls below compare value A. The second output is a window. It is high while the count is at or above compare value C and below compare value B.

The configuration (reload, three compares, a two-bit extension field and two polarity bits) arrives as parallel inputs. It is captured by a one-cycle commit strobe into a pending set. A commit that breaks the rules is refused, and an error flag reports it. The pending set is copied into the active set only at a period boundary, or at any time while the block is stopped, so a period never mixes two configurations.

In trigger mode the timer waits for a trigger pulse. Each trigger starts one full period, and the first output goes high on that start. Either of two fault inputs forces both outputs to their inactive level. They stay there until the next trigger. In free-running mode the trigger and fault inputs are ignored.

Top module: `pwm3_gen`

## Requirements
- R1: While `run` is high in free-running mode (`trig_mode`=0) and the configuration is held, the outputs repeat with a period of `n+1` strobes of `cnt_en`. The count steps from `n` down to 0 and then reloads `n`. While `run` is low, or while `cnt_en` is low, the count does not move.
- R2: Over any whole number of periods with `cnt_en` held high, `pwm_a` (not inverted) is high for `(n+1)-A` of every `n+1` cycles. That is, it is high while count >= A.
- R3: Over any whole number of periods with `cnt_en` held high, `pwm_b` (not inverted) is high for `B-C` of every `n+1` cycles. That is, it is high while C <= count < B.
- R4: A commit is accepted only if every compare lies in 1..n-1 and the extension field is 0. Otherwise `cfg_err` is 1 from the next cycle, the pending set keeps its old value, and the outputs carry on with the old values. An accepted commit clears `cfg_err`.
- R5: An accepted commit takes effect at the next reload (count 0 with a strobe), or on the next clock edge while `run` is low.
- R6: In trigger mode (`trig_mode`=1), `trig` with no fault present starts a period at count `n`. The next cycle, `pwm_a` is at its active level. With no trigger, the outputs stay inactive. Each period runs once, and a trigger while running restarts it.
- R7: In trigger mode, `fault_a` or `fault_b` drives both outputs inactive from the next cycle. They stay inactive until a trigger arrives with no fault present. A trigger in the same cycle as a fault is ignored.
- R8: `pol_a`/`pol_b` = 1 invert `pwm_a`/`pwm_b`. While `run` is low, each output sits at its inactive level, which equals its active polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Timer runs when 1; stopped and idle when 0 |
| trig_mode | input | 1 | 0 = free-running PWM, 1 = trigger/fault mode |
| cnt_en | input | 1 | Count-source strobe |
| cfg_n | input | W | Reload value n |
| cfg_a | input | W | Compare A (output A edge) |
| cfg_b | input | W | Compare B (window upper bound, exclusive) |
| cfg_c | input | W | Compare C (window lower bound, inclusive) |
| cfg_ext | input | XW | Extension field, must be 0 |
| cfg_pol_a | input | 1 | Invert output A |
| cfg_pol_b | input | 1 | Invert output B |
| cfg_commit | input | 1 | Capture the cfg_* inputs |
| trig | input | 1 | Trigger pulse (trigger mode) |
| fault_a | input | 1 | Force-inactive input 1 (trigger mode) |
| fault_b | input | 1 | Force-inactive input 2 (trigger mode) |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cfg_err | output | 1 | Last commit was refused |

## Verification
The outputs are combinational functions of registered state. A strobe, trigger, fault or run change therefore shows up on the outputs one clock edge later. A refused or accepted commit changes `cfg_err` one edge later. New values reach the outputs only at the edge that reloads the count. The bench drives its inputs one nanosecond after the rising edge and updates its model on the rising edge from those inputs. It compares all three outputs on every falling edge, so every result is checked in exactly the cycle it becomes due. Duty windows are additionally counted over whole numbers of periods, which makes them independent of phase.

// File: rtl/pwm3_pkg.sv
// Shared definitions for the three-compare PWM generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pwm3_pkg;
    // Operating mode selected by the trig_mode input
    typedef enum logic {
        PWM_FREE = 1'b0,
        PWM_TRIG = 1'b1
    } pwm_mode_e;

    // Number of compare registers held per configuration set
    localparam int NUM_CMP = 3;
    // Index of each compare in the packed compare array
    localparam int CMP_A = 0;
    localparam int CMP_B = 1;
    localparam int CMP_C = 2;
endpackage

// File: rtl/pwm3_cfg.sv
// Configuration capture: checks a committed set and, when legal, holds it as
// the pending set. Assumes cfg_* are stable in the cycle cfg_commit is high.
module pwm3_cfg
    import pwm3_pkg::*;
#(
    parameter int W  = 16,
    parameter int XW = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic [W-1:0] in_n,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    input  logic [XW-1:0] in_ext,
    input  logic         in_pol_a,
    input  logic         in_pol_b,
    output logic [W-1:0] pend_n,
    output logic [W-1:0] pend_a,
    output logic [W-1:0] pend_b,
    output logic [W-1:0] pend_c,
    output logic         pend_pol_a,
    output logic         pend_pol_b,
    output logic         err
);
    logic [W-1:0]       cmp_in [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_bad;
    logic               set_ok;

    assign cmp_in[CMP_A] = in_a;
    assign cmp_in[CMP_B] = in_b;
    assign cmp_in[CMP_C] = in_c;

    // Range check per compare: must be nonzero and strictly below the reload
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_rng
        assign cmp_bad[i] = (cmp_in[i] == '0) || (cmp_in[i] >= in_n);
    end

    assign set_ok = (cmp_bad == '0) && (in_ext == '0);

    // Pending set capture and error flag update on each commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_n     <= '0;
            pend_a     <= '0;
            pend_b     <= '0;
            pend_c     <= '0;
            pend_pol_a <= 1'b0;
            pend_pol_b <= 1'b0;
            err        <= 1'b0;
        end else if (commit) begin
            err <= !set_ok;
            if (set_ok) begin
                pend_n     <= in_n;
                pend_a     <= in_a;
                pend_b     <= in_b;
                pend_c     <= in_c;
                pend_pol_a <= in_pol_a;
                pend_pol_b <= in_pol_b;
            end
        end
    end

    // R4
    refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !set_ok) |=> ($stable(pend_n) && $stable(pend_a) &&
                                 $stable(pend_b) && $stable(pend_c)));

    // R4
    accepted_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && set_ok) |=> (!err && pend_a < pend_n && pend_b < pend_n &&
                                pend_c < pend_n));
endmodule

// File: rtl/pwm3_timer.sv
// Reload down-counter with active configuration set, trigger-mode one-shot
// and fault latch. Assumes trig_mode changes only while run is low.
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  pwm_mode_e    mode,
    input  logic         cnt_en,
    input  logic         trig,
    input  logic         fault,
    input  logic [W-1:0] pend_n,
    input  logic [W-1:0] pend_a,
    input  logic [W-1:0] pend_b,
    input  logic [W-1:0] pend_c,
    input  logic         pend_pol_a,
    input  logic         pend_pol_b,
    output logic [W-1:0] cnt,
    output logic [W-1:0] act_n,
    output logic [W-1:0] act_a,
    output logic [W-1:0] act_b,
    output logic [W-1:0] act_c,
    output logic         act_pol_a,
    output logic         act_pol_b,
    output logic         busy,
    output logic         kill
);
    logic trig_mode;
    logic start;
    logic load_set;
    logic step;

    assign trig_mode = (mode == PWM_TRIG);
    assign start     = run && trig_mode && trig && !fault;
    assign load_set  = !run || start ||
                       (!trig_mode && cnt_en && (cnt == '0));
    assign step      = run && cnt_en && (cnt != '0) && !start &&
                       (!trig_mode || busy);

    // Counter: reload on set load, otherwise step down on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_set) begin
            cnt <= pend_n;
        end else if (step) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Active set: copied from pending only at a period boundary or while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_n     <= '0;
            act_a     <= '0;
            act_b     <= '0;
            act_c     <= '0;
            act_pol_a <= 1'b0;
            act_pol_b <= 1'b0;
        end else if (load_set) begin
            act_n     <= pend_n;
            act_a     <= pend_a;
            act_b     <= pend_b;
            act_c     <= pend_c;
            act_pol_a <= pend_pol_a;
            act_pol_b <= pend_pol_b;
        end
    end

    // One-shot state: set by a trigger, cleared when the period ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (!run || !trig_mode) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
        end else if (busy && cnt_en && (cnt == '0)) begin
            busy <= 1'b0;
        end
    end

    // Fault latch: set by a fault in trigger mode, cleared by a clean trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kill <= 1'b0;
        end else if (run && trig_mode && fault) begin
            kill <= 1'b1;
        end else if (start) begin
            kill <= 1'b0;
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_n);

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_en && !(trig_mode && trig)) |=> $stable(cnt));

    // R6
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode && trig && !fault) |=> (busy && !kill && cnt == act_n));
endmodule

// File: rtl/pwm3_wave.sv
// Output shaping: compares the count with the active compares for each
// channel and applies polarity. Channel 0 is a threshold, channel 1 a window.
module pwm3_wave #(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic           en,
    input  logic [W-1:0]   cnt,
    input  logic [W-1:0]   lo  [NCH],
    input  logic [W-1:0]   hi  [NCH],
    input  logic [NCH-1:0] pol,
    output logic [NCH-1:0] wave
);
    logic [NCH-1:0] raw;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        if (ch == 0) begin : g_thr
            // Threshold channel: active from the top of the count down to lo
            assign raw[ch] = en && (cnt >= lo[ch]);
        end else begin : g_win
            // Window channel: active while lo <= count < hi
            assign raw[ch] = en && (cnt >= lo[ch]) && (cnt < hi[ch]);
        end
        assign wave[ch] = raw[ch] ^ pol[ch];
    end
endmodule

// File: rtl/pwm3_gen.sv
// Top of the three-compare PWM generator. Ties the configuration capture,
// the reload timer and the output shaping together. Assumes cnt_en, trig and
// the fault inputs are already synchronous to clk.
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int W  = 16,
    parameter int XW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          trig_mode,
    input  logic          cnt_en,
    input  logic [W-1:0]  cfg_n,
    input  logic [W-1:0]  cfg_a,
    input  logic [W-1:0]  cfg_b,
    input  logic [W-1:0]  cfg_c,
    input  logic [XW-1:0] cfg_ext,
    input  logic          cfg_pol_a,
    input  logic          cfg_pol_b,
    input  logic          cfg_commit,
    input  logic          trig,
    input  logic          fault_a,
    input  logic          fault_b,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          cfg_err
);
    localparam int NCH = 2;

    logic [W-1:0]   pend_n, pend_a, pend_b, pend_c;
    logic           pend_pol_a, pend_pol_b;
    logic [W-1:0]   cnt, act_n, act_a, act_b, act_c;
    logic           act_pol_a, act_pol_b;
    logic           busy, kill, fault, wave_en;
    pwm_mode_e      mode;
    logic [W-1:0]   lo [NCH];
    logic [W-1:0]   hi [NCH];
    logic [NCH-1:0] wave;

    assign mode  = pwm_mode_e'(trig_mode);
    assign fault = fault_a || fault_b;

    pwm3_cfg #(.W(W), .XW(XW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .commit(cfg_commit),
        .in_n(cfg_n), .in_a(cfg_a), .in_b(cfg_b), .in_c(cfg_c),
        .in_ext(cfg_ext), .in_pol_a(cfg_pol_a), .in_pol_b(cfg_pol_b),
        .pend_n(pend_n), .pend_a(pend_a), .pend_b(pend_b), .pend_c(pend_c),
        .pend_pol_a(pend_pol_a), .pend_pol_b(pend_pol_b), .err(cfg_err)
    );

    pwm3_timer #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .cnt_en(cnt_en),
        .trig(trig), .fault(fault),
        .pend_n(pend_n), .pend_a(pend_a), .pend_b(pend_b), .pend_c(pend_c),
        .pend_pol_a(pend_pol_a), .pend_pol_b(pend_pol_b),
        .cnt(cnt), .act_n(act_n), .act_a(act_a), .act_b(act_b), .act_c(act_c),
        .act_pol_a(act_pol_a), .act_pol_b(act_pol_b), .busy(busy), .kill(kill)
    );

    // Output enable: free-running whenever run, one-shot only while armed
    assign wave_en = run && ((mode == PWM_FREE) || (busy && !kill));

    assign lo[0] = act_a;
    assign hi[0] = act_n;
    assign lo[1] = act_c;
    assign hi[1] = act_b;

    pwm3_wave #(.W(W), .NCH(NCH)) u_wave (
        .en(wave_en), .cnt(cnt), .lo(lo), .hi(hi),
        .pol({act_pol_b, act_pol_a}), .wave(wave)
    );

    assign pwm_a = wave[0];
    assign pwm_b = wave[1];

    // R7
    fault_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode && fault) |=> (pwm_a == act_pol_a && pwm_b == act_pol_b));

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_a == act_pol_a && pwm_b == act_pol_b));
endmodule

// File: tb/tb_pwm3_gen.sv
`timescale 1ns/1ps
module tb_pwm3_gen;
    localparam int W  = 16;
    localparam int XW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 0, trig_mode = 0, cnt_en = 0;
    logic [W-1:0] cfg_n = '0, cfg_a = '0, cfg_b = '0, cfg_c = '0;
    logic [XW-1:0] cfg_ext = '0;
    logic cfg_pol_a = 0, cfg_pol_b = 0, cfg_commit = 0;
    logic trig = 0, fault_a = 0, fault_b = 0;
    logic pwm_a, pwm_b, cfg_err;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    // reference model state
    int pn = 0, pa = 0, pb = 0, pc = 0, ppa = 0, ppb = 0;
    int an = 0, aa = 0, ab = 0, ac = 0, apa = 0, apb = 0;
    int mcnt = 0, mbusy = 0, mkill = 0, merr = 0;

    always #2.5 clk = ~clk;

    pwm3_gen #(.W(W), .XW(XW)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .trig_mode(trig_mode),
        .cnt_en(cnt_en), .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .cfg_c(cfg_c), .cfg_ext(cfg_ext), .cfg_pol_a(cfg_pol_a),
        .cfg_pol_b(cfg_pol_b), .cfg_commit(cfg_commit), .trig(trig),
        .fault_a(fault_a), .fault_b(fault_b), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .cfg_err(cfg_err)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic take_active();
        an = pn; aa = pa; ab = pb; ac = pc; apa = ppa; apb = ppb;
    endtask

    // Behavioural model, advanced on each rising edge from the driven inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            pn = 0; pa = 0; pb = 0; pc = 0; ppa = 0; ppb = 0;
            an = 0; aa = 0; ab = 0; ac = 0; apa = 0; apb = 0;
            mcnt = 0; mbusy = 0; mkill = 0; merr = 0;
        end else begin
            bit ok, flt;
            flt = fault_a || fault_b;
            if (!run) begin
                mcnt = pn; take_active(); mbusy = 0;
            end else if (!trig_mode) begin
                mbusy = 0;
                if (cnt_en) begin
                    if (mcnt == 0) begin mcnt = pn; take_active(); end
                    else mcnt--;
                end
            end else begin
                if (flt) mkill = 1;
                if (trig && !flt) begin
                    mcnt = pn; take_active(); mbusy = 1; mkill = 0;
                end else if (mbusy && cnt_en) begin
                    if (mcnt == 0) mbusy = 0; else mcnt--;
                end
            end
            if (cfg_commit) begin
                ok = (cfg_ext == 0) &&
                     (cfg_a >= 1) && (int'(cfg_a) < int'(cfg_n)) &&
                     (cfg_b >= 1) && (int'(cfg_b) < int'(cfg_n)) &&
                     (cfg_c >= 1) && (int'(cfg_c) < int'(cfg_n));
                merr = ok ? 0 : 1;
                if (ok) begin
                    pn = cfg_n; pa = cfg_a; pb = cfg_b; pc = cfg_c;
                    ppa = cfg_pol_a; ppb = cfg_pol_b;
                end
            end
        end
    end

    // Compare all outputs with the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            int en, ea, eb;
            en = run && (!trig_mode || (mbusy && !mkill));
            ea = (en && mcnt >= aa) ? 1 : 0;
            eb = (en && mcnt >= ac && mcnt < ab) ? 1 : 0;
            check(pwm_a, ea ^ apa, cur_req, "pwm_a");
            check(pwm_b, eb ^ apb, cur_req, "pwm_b");
            check(cfg_err, merr, "R4", "cfg_err");
        end
    end

    task automatic tick(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic commit(input int n, input int a, input int b, input int c,
                          input int ext, input bit pa_i, input bit pb_i);
        @(posedge clk); #1;
        cfg_n = W'(n); cfg_a = W'(a); cfg_b = W'(b); cfg_c = W'(c);
        cfg_ext = XW'(ext); cfg_pol_a = pa_i; cfg_pol_b = pb_i; cfg_commit = 1;
        @(posedge clk); #1;
        cfg_commit = 0;
    endtask

    task automatic pulse_trig();
        trig = 1; tick(1); trig = 0;
    endtask

    // Count active cycles of each output over k whole periods
    task automatic duty(input int k, input int per, input int exp_a, input int exp_b,
                        input int inv_a, input int inv_b, input string req);
        int ha = 0, hb = 0;
        for (int i = 0; i < k * per; i++) begin
            @(negedge clk);
            ha += (pwm_a ^ inv_a);
            hb += (pwm_b ^ inv_b);
        end
        check(ha, k * exp_a, req, "pwm_a active cycles");
        check(hb, k * exp_b, req, "pwm_b active cycles");
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk);
        check(pwm_a, 0, "R8", "reset pwm_a");
        check(pwm_b, 0, "R8", "reset pwm_b");
        check(cfg_err, 0, "R4", "reset cfg_err");
        @(posedge clk); #1;
        rst_n = 1;
        cmp_on = 1;

        // R2 R3: free-running, n=9 A=4 B=7 C=2, continuous strobe
        cur_req = "R2";
        commit(9, 4, 7, 2, 0, 0, 0);
        run = 1; cnt_en = 1;
        tick(3);
        duty(3, 10, 6, 5, 0, 0, "R2");
        cur_req = "R3";
        duty(2, 10, 6, 5, 0, 0, "R3");

        // R1: strobe every third clock
        cur_req = "R1";
        for (int i = 0; i < 60; i++) begin
            cnt_en = (i % 3 == 0); tick(1);
        end
        cnt_en = 0; tick(7);

        // R4: refused commits keep old set
        cur_req = "R4";
        cnt_en = 1;
        commit(9, 0, 7, 2, 0, 0, 0);
        tick(4);
        commit(9, 4, 9, 2, 0, 0, 0);
        tick(4);
        commit(9, 4, 7, 2, 1, 0, 0);
        tick(4);
        duty(2, 10, 6, 5, 0, 0, "R4");

        // R5: mid-period change applied at reload
        cur_req = "R5";
        tick(3);
        commit(5, 1, 4, 3, 0, 0, 0);
        tick(20);
        duty(3, 6, 5, 1, 0, 0, "R5");

        // R8: polarity inversion and idle level
        cur_req = "R8";
        commit(7, 3, 6, 1, 0, 1, 1);
        tick(20);
        duty(2, 8, 5, 5, 1, 1, "R8");
        run = 0; tick(5);
        commit(7, 3, 6, 1, 0, 0, 1);
        tick(3);

        // R6: trigger mode one-shots, strobe every other clock
        cur_req = "R6";
        trig_mode = 1; run = 1;
        for (int i = 0; i < 12; i++) begin cnt_en = i[0]; tick(1); end
        pulse_trig();
        for (int i = 0; i < 30; i++) begin cnt_en = i[0]; tick(1); end
        pulse_trig();
        tick(5);
        pulse_trig();
        cnt_en = 1; tick(20);

        // R7: faults force inactive until the next clean trigger
        cur_req = "R7";
        pulse_trig(); tick(2);
        fault_a = 1; tick(1); fault_a = 0; tick(4);
        pulse_trig(); tick(1);
        fault_b = 1; trig = 1; tick(1); fault_b = 0; trig = 0; tick(6);
        pulse_trig(); tick(12);

        // R1: free-running mode ignores trigger and faults
        cur_req = "R1";
        run = 0; tick(2); trig_mode = 0; tick(1); run = 1;
        fault_a = 1; trig = 1; tick(5); fault_a = 0; trig = 0;
        tick(10);

        cmp_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule